// File: doc/BRIEF.md
# Coprocessor Host Byte Port

This block is the host-facing side of a signal-processing coprocessor. It holds a 16-bit data word and a 16-bit status word. The host reaches them through two byte-wide ports, selected by one line: a status port (read-only) and a data port. The host drives one-cycle read or write strobes. A byte sequencer decides which half of the data word each data-port access moves. It also decides when the request flag drops, which tells the coprocessor that the host has finished with the word.

On the core side, the coprocessor can load the data word from its 16-bit bus, read it with or without handshaking, and load the status word. Any core load of the data word, and any handshaking read, raises the request flag again. The status word is packed as follows: request flag bit 15, user flags bits 14 and 13, byte-phase flag bit 12, transfer-engine enable bit 11, byte-mode bit 10, serial out/in mode bits 9 and 8, interrupt enable bit 7, general outputs bits 1 and 0. All other bits read as zero.

The byte sequencer is a two-state machine:
- PH_LOW: the next access moves the low byte. A 16-bit-mode access takes the transition LOW_TO_HIGH.
- PH_HIGH: the next access moves the high byte. A 16-bit-mode access takes the transition HIGH_TO_LOW, which completes the word.
- In 8-bit mode every access takes the transition HOLD and stays in the current state.

Top module: `dsp_host_port`

## Requirements
- R1: After reset the status word is 16'h8000 (only the request flag set), the data word is 16'h0000, and the byte-phase flag is 0.
- R2: A host read of the status port (host_sel_data=0) returns status bits 15..8. A host write to the status port changes neither word.
- R3: In 16-bit mode (status bit 10 = 0), a data-port access in phase 0 moves data bits 7..0 (read or write) and sets the byte-phase flag (status bit 12).
- R4: In 16-bit mode, a data-port access in phase 1 moves data bits 15..8, clears the byte-phase flag and clears the request flag (status bit 15).
- R5: In 8-bit mode (status bit 10 = 1), every data-port access moves data bits 7..0 only, clears the request flag and leaves the byte-phase flag unchanged. A host write leaves data bits 15..8 unchanged.
- R6: A core write of the data word loads all 16 bits and sets the request flag on the next edge.
- R7: A core handshaking read sets the request flag. Observing the data word without the handshaking strobe leaves the request flag unchanged.
- R8: A core write of the status word loads bits 14, 13, 11, 10, 9, 8, 7, 1 and 0. Bits 15 and 12 keep their values, and all other bits stay zero.
- R9: When a host data access and a core data write or handshaking read fall in the same cycle, the core value and the set request flag win, while the byte phase still advances.
- R10: Each strobe pulse counts as exactly one access, so strobes on consecutive cycles count as consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd_stb | input | 1 | Host read strobe, one cycle per access |
| host_wr_stb | input | 1 | Host write strobe, one cycle per access |
| host_sel_data | input | 1 | 1 selects the data port, 0 selects the status port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid during the read strobe cycle |
| core_dr_wr | input | 1 | Core loads the data word from core_wdata |
| core_dr_rd_hs | input | 1 | Core handshaking read of the data word |
| core_sr_wr | input | 1 | Core loads the status word from core_wdata |
| core_wdata | input | 16 | Core write bus |
| core_dr | output | 16 | Current data word |
| core_sr | output | 16 | Current status word |
| core_req | output | 1 | Request flag |
| core_phase | output | 1 | Byte-phase flag |

## Verification
host_rdata is combinational. The byte for a read is therefore due in the same cycle as its strobe. The monitor samples it on the falling edge inside that cycle and compares it against the item the driver queued. Every register effect (data word, status word, request and phase flags) is due one edge after the stimulus. The driver returns just after that edge and only then compares core_dr and core_sr. Collision and back-to-back cases use the same one-edge rule, so no check depends on the order of processes at a clock edge.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam int BIT_REQ   = 15;
    localparam int BIT_PHASE = 12;
    localparam int BIT_BMODE = 10;

    // bits the core may load: 14,13,11,10,9,8,7,1,0
    localparam logic [WORD_W-1:0] CORE_SR_MASK = 16'h6F83;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/hp_byte_seq.sv
module hp_byte_seq
    import hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic byte_mode,
    output logic phase_hi,
    output logic lane_hi,
    output logic done
);
    phase_e state_q, state_d;

    // next state: LOW_TO_HIGH, HIGH_TO_LOW, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (acc && !byte_mode) state_d = PH_HIGH;
            PH_HIGH: if (acc && !byte_mode) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_LOW;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        phase_hi = 1'b0;
        lane_hi  = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            PH_LOW: begin
                done = acc && byte_mode;
            end
            PH_HIGH: begin
                phase_hi = 1'b1;
                lane_hi  = !byte_mode;
                done     = acc;
            end
            default: ;
        endcase
    end

    p_phase_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !byte_mode && !phase_hi) |=> phase_hi);
    p_phase_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !byte_mode && phase_hi) |=> !phase_hi);
    p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && byte_mode) |=> $stable(phase_hi));
endmodule

// File: rtl/hp_data_reg.sv
module hp_data_reg #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              lane_hi,
    input  logic [LANE_W-1:0] host_byte,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_data,
    output logic [DATA_W-1:0] word
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        logic              hit;
        assign hit = host_wr && (g == int'(lane_hi));
        always_ff @(posedge clk) begin
            if (!rst_n)       lane_q <= '0;
            else if (core_wr) lane_q <= core_data[g*LANE_W +: LANE_W];
            else if (hit)     lane_q <= host_byte;
        end
        assign word[g*LANE_W +: LANE_W] = lane_q;
    end

    p_core_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |=> (word == $past(core_data)));
    p_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !lane_hi && !core_wr) |=>
            ($stable(word[DATA_W-1:LANE_W]) && word[LANE_W-1:0] == $past(host_byte)));
endmodule

// File: rtl/hp_status_reg.sv
module hp_status_reg
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              req_set,
    input  logic              req_clr,
    input  logic              phase_hi,
    output logic              req,
    output logic              byte_mode,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] cfg_q;
    logic              req_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_data & CORE_SR_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       req_q <= 1'b1;
        else if (req_set) req_q <= 1'b1;
        else if (req_clr) req_q <= 1'b0;
    end

    always_comb begin
        word            = cfg_q & CORE_SR_MASK;
        word[BIT_REQ]   = req_q;
        word[BIT_PHASE] = phase_hi;
    end

    assign req       = req_q;
    assign byte_mode = cfg_q[BIT_BMODE];

    p_req_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_set |=> req);
    p_req_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr && !req_set) |=> !req);
    p_req_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !req_set && !req_clr) |=> $stable(req));
endmodule

// File: rtl/dsp_host_port.sv
module dsp_host_port
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_stb,
    input  logic              host_wr_stb,
    input  logic              host_sel_data,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              core_dr_wr,
    input  logic              core_dr_rd_hs,
    input  logic              core_sr_wr,
    input  logic [WORD_W-1:0] core_wdata,
    output logic [WORD_W-1:0] core_dr,
    output logic [WORD_W-1:0] core_sr,
    output logic              core_req,
    output logic              core_phase
);
    logic data_acc, data_wr;
    logic phase_hi, lane_hi, seq_done, byte_mode, req;
    logic [WORD_W-1:0] dr_word, sr_word;

    assign data_acc = host_sel_data && (host_rd_stb || host_wr_stb);
    assign data_wr  = host_sel_data && host_wr_stb;

    hp_byte_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (data_acc),
        .byte_mode (byte_mode),
        .phase_hi  (phase_hi),
        .lane_hi   (lane_hi),
        .done      (seq_done)
    );

    hp_data_reg #(.DATA_W(WORD_W), .LANE_W(BYTE_W)) u_dr (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (data_wr),
        .lane_hi   (lane_hi),
        .host_byte (host_wdata),
        .core_wr   (core_dr_wr),
        .core_data (core_wdata),
        .word      (dr_word)
    );

    hp_status_reg u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (core_sr_wr),
        .cfg_data  (core_wdata),
        .req_set   (core_dr_wr || core_dr_rd_hs),
        .req_clr   (seq_done),
        .phase_hi  (phase_hi),
        .req       (req),
        .byte_mode (byte_mode),
        .word      (sr_word)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd_stb) begin
            if (!host_sel_data) host_rdata = sr_word[WORD_W-1:BYTE_W];
            else if (lane_hi)   host_rdata = dr_word[WORD_W-1:BYTE_W];
            else                host_rdata = dr_word[BYTE_W-1:0];
        end
    end

    assign core_dr    = dr_word;
    assign core_sr    = sr_word;
    assign core_req   = req;
    assign core_phase = phase_hi;

    p_status_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_stb && !host_rd_stb && !host_sel_data && !core_dr_wr
         && !core_dr_rd_hs && !core_sr_wr) |=> ($stable(core_sr) && $stable(core_dr)));
    p_hs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_dr_rd_hs |=> core_req);
endmodule

// File: tb/test_dsp_host_port.sv
module test_dsp_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd_stb = 1'b0, host_wr_stb = 1'b0, host_sel_data = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        core_dr_wr = 1'b0, core_dr_rd_hs = 1'b0, core_sr_wr = 1'b0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_dr, core_sr;
    logic        core_req, core_phase;

    int checks = 0;
    int failures = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    dsp_host_port i_dsp_host_port (
        .clk(clk), .rst_n(rst_n),
        .host_rd_stb(host_rd_stb), .host_wr_stb(host_wr_stb),
        .host_sel_data(host_sel_data), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .core_dr_wr(core_dr_wr), .core_dr_rd_hs(core_dr_rd_hs),
        .core_sr_wr(core_sr_wr), .core_wdata(core_wdata),
        .core_dr(core_dr), .core_sr(core_sr),
        .core_req(core_req), .core_phase(core_phase)
    );

    // monitor: read bytes are due inside the strobe cycle
    always @(negedge clk) begin
        if (rst_n && host_rd_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected read: actual %02h expected none", host_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    failures++;
                    $display("FAIL %s read byte: actual %02h expected %02h", t, host_rdata, e);
                end
            end
        end
    end

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %04h expected %04h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        host_rd_stb = 0; host_wr_stb = 0; host_sel_data = 0; host_wdata = '0;
        core_dr_wr = 0; core_dr_rd_hs = 0; core_sr_wr = 0; core_wdata = '0;
    endtask

    // driver: one-cycle stimulus; returns just after the edge that consumed it
    task automatic op(input string tag, input logic rd, input logic wr, input logic sel,
                      input logic [7:0] wd, input logic [7:0] exp_byte,
                      input logic cdw, input logic chs, input logic csw,
                      input logic [15:0] cwd);
        @(posedge clk); #1;
        if (rd) begin exp_q.push_back(exp_byte); tag_q.push_back(tag); end
        host_rd_stb = rd; host_wr_stb = wr; host_sel_data = sel; host_wdata = wd;
        core_dr_wr = cdw; core_dr_rd_hs = chs; core_sr_wr = csw; core_wdata = cwd;
        @(posedge clk); #1;
        clear_in();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset
        chk16("R1 sr", core_sr, 16'h8000);
        chk16("R1 dr", core_dr, 16'h0000);
        chk16("R1 phase", {15'b0, core_phase}, 16'h0);
        // R2 status port
        op("R2", 1, 0, 0, 8'h00, 8'h80, 0, 0, 0, 16'h0);
        op("R2", 0, 1, 0, 8'hFF, 8'h00, 0, 0, 0, 16'h0);
        chk16("R2 sr after status write", core_sr, 16'h8000);
        chk16("R2 dr after status write", core_dr, 16'h0000);
        // R3/R4 host writes, 16-bit mode
        op("R3", 0, 1, 1, 8'hAB, 8'h00, 0, 0, 0, 16'h0);
        chk16("R3 dr", core_dr, 16'h00AB);
        chk16("R3 sr", core_sr, 16'h9000);
        op("R3 status", 1, 0, 0, 8'h00, 8'h90, 0, 0, 0, 16'h0);
        op("R4", 0, 1, 1, 8'hCD, 8'h00, 0, 0, 0, 16'h0);
        chk16("R4 dr", core_dr, 16'hCDAB);
        chk16("R4 sr", core_sr, 16'h0000);
        // R6 core write
        op("R6", 0, 0, 0, 8'h00, 8'h00, 1, 0, 0, 16'h5A3C);
        chk16("R6 dr", core_dr, 16'h5A3C);
        chk16("R6 sr", core_sr, 16'h8000);
        // R3/R4 host reads
        op("R3 low read", 1, 0, 1, 8'h00, 8'h3C, 0, 0, 0, 16'h0);
        chk16("R3 sr after read", core_sr, 16'h9000);
        op("R4 high read", 1, 0, 1, 8'h00, 8'h5A, 0, 0, 0, 16'h0);
        chk16("R4 sr after read", core_sr, 16'h0000);
        // R7 handshaking vs plain read
        op("R7", 0, 0, 0, 8'h00, 8'h00, 0, 1, 0, 16'h0);
        chk16("R7 hs read", core_sr, 16'h8000);
        op("R7", 1, 0, 1, 8'h00, 8'h3C, 0, 0, 0, 16'h0);
        op("R7", 1, 0, 1, 8'h00, 8'h5A, 0, 0, 0, 16'h0);
        repeat (3) @(posedge clk); #1;
        chk16("R7 plain read keeps req", core_sr, 16'h0000);
        chk16("R7 dr visible", core_dr, 16'h5A3C);
        // R8 status load, then R5 8-bit mode
        op("R8", 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 16'hFFFF);
        chk16("R8 sr", core_sr, 16'h6F83);
        op("R5", 0, 0, 0, 8'h00, 8'h00, 1, 0, 0, 16'h7788);
        chk16("R5 req set", core_sr, 16'hEF83);
        op("R5 write", 0, 1, 1, 8'h11, 8'h00, 0, 0, 0, 16'h0);
        chk16("R5 dr high kept", core_dr, 16'h7711);
        chk16("R5 sr", core_sr, 16'h6F83);
        op("R5", 0, 0, 0, 8'h00, 8'h00, 1, 0, 0, 16'h99AA);
        op("R5 read", 1, 0, 1, 8'h00, 8'hAA, 0, 0, 0, 16'h0);
        chk16("R5 sr after read", core_sr, 16'h6F83);
        op("R5 read again", 1, 0, 1, 8'h00, 8'hAA, 0, 0, 0, 16'h0);
        chk16("R5 phase held", core_sr, 16'h6F83);
        // R9 collisions
        op("R9", 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 16'h0000);
        chk16("R9 sr cleared", core_sr, 16'h0000);
        op("R9 write collide", 0, 1, 1, 8'h55, 8'h00, 1, 0, 0, 16'hBEEF);
        chk16("R9 dr core wins", core_dr, 16'hBEEF);
        chk16("R9 sr phase advanced", core_sr, 16'h9000);
        op("R9", 0, 1, 1, 8'h66, 8'h00, 0, 0, 0, 16'h0);
        chk16("R9 dr high", core_dr, 16'h66EF);
        chk16("R9 sr", core_sr, 16'h0000);
        op("R9", 1, 0, 1, 8'h00, 8'hEF, 0, 0, 0, 16'h0);
        op("R9 read collide", 1, 0, 1, 8'h00, 8'h66, 0, 1, 0, 16'h0);
        chk16("R9 req kept by core", core_sr, 16'h8000);
        // R10 back-to-back strobes
        @(posedge clk); #1;
        host_wr_stb = 1; host_sel_data = 1; host_wdata = 8'h01;
        @(posedge clk); #1;
        host_wdata = 8'h02;
        @(posedge clk); #1;
        clear_in();
        chk16("R10 dr", core_dr, 16'h0201);
        chk16("R10 sr", core_sr, 16'h0000);
        // R8 status load keeps phase and req
        op("R8", 0, 1, 1, 8'h33, 8'h00, 0, 0, 0, 16'h0);
        op("R8 keep", 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 16'hFBFF);
        chk16("R8 sr keeps bits 15 and 12", core_sr, 16'h7B83);
        op("R8", 0, 1, 1, 8'h44, 8'h00, 0, 0, 0, 16'h0);
        chk16("R8 16-bit kept", core_dr, 16'h4433);
        chk16("R8 sr final", core_sr, 16'h6B83);
        @(posedge clk); #1;
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule